// File: doc/BRIEF.md
# Two-Phase Piezo Drive Pulse Generator

This block produces two square-wave drive phases for a piezo motor from one free-running period counter clocked by the master clock. Three byte-wide settings control the waveform: the high time of each phase (duty), the delay of the second phase against the first (shift), and an extra count that lengthens the period and so lowers the switching frequency. A control bit picks whether the second phase lags or leads the first.

A setting of zero is a special code. It selects half the period for duty and a quarter period (90°) for shift. A nonzero value is a raw count of master-clock cycles. The period offset applies only while the resonance tracker reports itself stopped. All writes land in shadow registers. They reach the waveform only at the end of a period, so no pulse is ever cut short or stretched.

Top module: `piezo_drive_pwm`

## Requirements
- R1: While `pd_n` is low, both outputs are low and all settings return to zero. After release, the waveform uses the defaults: duty floor(P/2), shift floor(P/4), direction lag and no offset. P is the active period in master-clock cycles.
- R2: A duty setting of 0 gives `phase_a` a high time of floor(P/2) cycles in each period.
- R3: A shift setting of 0 makes `phase_b` rise floor(P/4) cycles after `phase_a` when the direction bit is 0.
- R4: A nonzero duty setting D gives both phases a high time of D cycles. `phase_a` rises when the counter is at zero.
- R5: A nonzero duty or shift value above floor(63*P/125) is clamped to floor(63*P/125).
- R6: A nonzero shift setting S, with the direction bit 0, makes `phase_b` rise S cycles after `phase_a`.
- R7: Writing address 3 with bit 0 set makes `phase_b` lead `phase_a`. `phase_b` then rises P-S cycles after `phase_a`.
- R8: While `track_on` is low, P equals `nom_period` plus the offset register. While `track_on` is high, P equals `nom_period`.
- R9: A write takes effect only at the next period boundary. A write made while `phase_a` is high does not change that pulse.
- R10: Register map on `wr_addr`: 0 selects duty, 1 selects shift, 2 selects offset, 3 selects control (bit 0 = direction). A write occurs on a clock edge with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| pd_n | input | 1 | Active-low power-down; asynchronous reset of all state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| track_on | input | 1 | High while frequency tracking runs |
| nom_period | input | CNT_W | Nominal period in master-clock cycles |
| phase_a | output | 1 | Drive phase A |
| phase_b | output | 1 | Drive phase B |

## Verification
The assertions assume that `nom_period` is at least 4 and changes only while the block runs at a steady setting. They also assume that `track_on` and `nom_period` are read only at a period boundary, so a change between boundaries is harmless. The stimulus holds `nom_period` at 125 throughout. It toggles `track_on` only between measurements. After each write it measures only once a full period has passed, so every measured pulse comes from one consistent setting.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  typedef enum logic [1:0] {
    SEL_DUTY  = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_OFFS  = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [7:0] duty;
    logic [7:0] shift;
    logic [7:0] offs;
    logic       lead;
  } drive_cfg_t;
endpackage

// File: rtl/pdp_regs.sv
module pdp_regs
  import pdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output drive_cfg_t cfg
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DUTY:  cfg.duty  <= wr_data;
        SEL_SHIFT: cfg.shift <= wr_data;
        SEL_OFFS:  cfg.offs  <= wr_data;
        SEL_CTRL:  cfg.lead  <= wr_data[0];
      endcase
    end
  end

  // R10: a write changes only the register it selects
  assert_write_selects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> ($stable(cfg.shift) && $stable(cfg.offs) && $stable(cfg.lead)));
endmodule

// File: rtl/pdp_timebase.sv
module pdp_timebase
  import pdp_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int PW = CNT_W + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  drive_cfg_t       cfg_i,
  input  logic             track_i,
  input  logic [CNT_W-1:0] nom_i,
  output logic [PW-1:0]    cnt,
  output logic [PW-1:0]    per_act,
  output logic [PW-1:0]    duty_act,
  output logic [PW-1:0]    shift_act,
  output logic             lead_act,
  output logic             wrap
);
  function automatic logic [PW-1:0] clamp_lim(input logic [PW-1:0] per);
    logic [PW+6:0] t;
    t = (PW+7)'(per) * (PW+7)'(63);
    return PW'(t / (PW+7)'(125));
  endfunction

  function automatic logic [PW-1:0] period_len(input logic [CNT_W-1:0] nom,
                                               input logic [7:0] offs,
                                               input logic trk);
    return trk ? PW'(nom) : PW'(nom) + PW'(offs);
  endfunction

  function automatic logic [PW-1:0] resolve(input logic [7:0] code,
                                            input logic [PW-1:0] per,
                                            input logic quarter);
    logic [PW-1:0] lim;
    logic [PW-1:0] raw;
    lim = clamp_lim(per);
    raw = PW'(code);
    if (code == 8'd0) return quarter ? (per >> 2) : (per >> 1);
    return (raw > lim) ? lim : raw;
  endfunction

  logic [PW-1:0] per_nx;
  logic [PW:0]   cnt_inc;

  assign per_nx  = period_len(nom_i, cfg_i.offs, track_i);
  assign cnt_inc = (PW+1)'(cnt) + (PW+1)'(1);
  assign wrap    = (cnt_inc >= (PW+1)'(per_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      per_act   <= '0;
      duty_act  <= '0;
      shift_act <= '0;
      lead_act  <= 1'b0;
    end else if (wrap) begin
      cnt       <= '0;
      per_act   <= per_nx;
      duty_act  <= resolve(cfg_i.duty, per_nx, 1'b0);
      shift_act <= resolve(cfg_i.shift, per_nx, 1'b1);
      lead_act  <= cfg_i.lead;
    end else begin
      cnt <= cnt_inc[PW-1:0];
    end
  end

  assert_cnt_below_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> (cnt < per_act));
  assert_duty_within_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act <= per_act) && (shift_act <= per_act));
  assert_hold_until_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_act) && $stable(shift_act) && $stable(per_act) && $stable(lead_act)));
  assert_track_nominal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && track_i) |=> (per_act == PW'($past(nom_i))));
endmodule

// File: rtl/pdp_phase_gen.sv
module pdp_phase_gen #(
  parameter int PW = 9
)(
  input  logic [PW-1:0] cnt,
  input  logic [PW-1:0] per,
  input  logic [PW-1:0] duty,
  input  logic [PW-1:0] shift,
  input  logic          lead,
  output logic          pa,
  output logic          pb
);
  function automatic logic [PW-1:0] b_pos(input logic [PW-1:0] c,
                                          input logic [PW-1:0] p,
                                          input logic [PW-1:0] s,
                                          input logic ld);
    logic [PW:0] sum;
    if (ld) begin
      sum = (PW+1)'(c) + (PW+1)'(s);
      if (sum >= (PW+1)'(p)) sum = sum - (PW+1)'(p);
      return sum[PW-1:0];
    end
    if (c >= s) return c - s;
    return c + (p - s);
  endfunction

  logic [PW-1:0] pos_b;
  assign pos_b = b_pos(cnt, per, shift, lead);
  assign pa    = (cnt < duty);
  assign pb    = (pos_b < duty);
endmodule

// File: rtl/piezo_drive_pwm.sv
module piezo_drive_pwm
  import pdp_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             pd_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             track_on,
  input  logic [CNT_W-1:0] nom_period,
  output logic             phase_a,
  output logic             phase_b
);
  localparam int PW = CNT_W + 1;

  drive_cfg_t    cfg;
  logic [PW-1:0] cnt, per_act, duty_act, shift_act;
  logic          lead_act, wrap;

  pdp_regs u_regs (
    .clk(clk), .rst_n(pd_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  pdp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(pd_n), .cfg_i(cfg), .track_i(track_on), .nom_i(nom_period),
    .cnt(cnt), .per_act(per_act), .duty_act(duty_act), .shift_act(shift_act),
    .lead_act(lead_act), .wrap(wrap)
  );

  pdp_phase_gen #(.PW(PW)) u_pg (
    .cnt(cnt), .per(per_act), .duty(duty_act), .shift(shift_act),
    .lead(lead_act), .pa(phase_a), .pb(phase_b)
  );

  assert_a_rise_at_zero_R4: assert property (@(posedge clk) disable iff (!pd_n)
    $rose(phase_a) |-> (cnt == '0));
  assert_a_low_before_wrap_R4: assert property (@(posedge clk) disable iff (!pd_n)
    (wrap && duty_act < per_act) |-> !phase_a);
endmodule

// File: tb/piezo_drive_pwm_tb.sv
module piezo_drive_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOM = 125;

  logic clk = 1'b0;
  logic pd_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic track_on = 1'b1;
  logic [7:0] nom_period = 8'(NOM);
  logic phase_a, phase_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piezo_drive_pwm #(.CNT_W(8)) u_dut (
    .clk(clk), .pd_n(pd_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .track_on(track_on), .nom_period(nom_period), .phase_a(phase_a), .phase_b(phase_b)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_a_rise();
    logic prev;
    @(negedge clk); prev = phase_a;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (phase_a && !prev) return;
      prev = phase_a;
    end
  endtask

  task automatic measure(output int per, output int hi, output int bdel);
    logic pa_prev, pb_prev;
    sync_a_rise();
    pa_prev = phase_a; pb_prev = phase_b;
    per = -1; hi = -1; bdel = -1;
    for (int n = 1; n < 2000; n++) begin
      @(negedge clk);
      if (hi < 0 && !phase_a) hi = n;
      if (bdel < 0 && phase_b && !pb_prev) bdel = n;
      if (phase_a && !pa_prev) begin per = n; break; end
      pa_prev = phase_a; pb_prev = phase_b;
    end
  endtask

  task automatic settle_measure(output int per, output int hi, output int bdel);
    int p0, h0, b0;
    measure(p0, h0, b0);
    measure(per, hi, bdel);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check("R1", "phase_a in power-down", int'(phase_a), 0);
    check("R1", "phase_b in power-down", int'(phase_b), 0);
    pd_n = 1'b1;
  endtask

  task automatic t_defaults();
    int p, h, b;
    settle_measure(p, h, b);
    check("R8", "default period", p, NOM);
    check("R2", "default duty", h, NOM/2);
    check("R3", "default shift", b, NOM/4);
  endtask

  task automatic t_raw_duty();
    int p, h, b;
    wr(2'd0, 8'h0D);
    settle_measure(p, h, b);
    check("R4", "duty 0x0D", h, 13);
    wr(2'd0, 8'h3F);
    settle_measure(p, h, b);
    check("R4", "duty 0x3F", h, 63);
  endtask

  task automatic t_clamp();
    int p, h, b;
    wr(2'd0, 8'h50);
    wr(2'd1, 8'h70);
    settle_measure(p, h, b);
    check("R5", "duty clamp", h, (63*NOM)/125);
    check("R5", "shift clamp", b, (63*NOM)/125);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_raw_shift();
    int p, h, b;
    wr(2'd1, 8'h20);
    settle_measure(p, h, b);
    check("R6", "shift 0x20", b, 32);
    check("R10", "duty untouched by shift write", h, NOM/2);
  endtask

  task automatic t_lead();
    int p, h, b;
    wr(2'd1, 8'd20);
    wr(2'd3, 8'h01);
    settle_measure(p, h, b);
    check("R7", "lead delay", b, NOM - 20);
    wr(2'd3, 8'h00);
    settle_measure(p, h, b);
    check("R7", "lag restored", b, 20);
  endtask

  task automatic t_offset();
    int p, h, b;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd5);
    settle_measure(p, h, b);
    check("R8", "offset ignored while tracking", p, NOM);
    track_on = 1'b0;
    settle_measure(p, h, b);
    check("R8", "offset period", p, NOM + 5);
    check("R2", "default duty on offset period", h, (NOM + 5)/2);
    check("R3", "default shift on offset period", b, (NOM + 5)/4);
    track_on = 1'b1;
    settle_measure(p, h, b);
    check("R8", "tracking resumed", p, NOM);
  endtask

  task automatic t_boundary_apply();
    int hi, p, h, b;
    logic prev;
    sync_a_rise();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h20;
    hi = -1; prev = 1'b1;
    for (int n = 1; n < 400; n++) begin
      @(negedge clk);
      if (n == 1) wr_en = 1'b0;
      if (!phase_a) begin hi = n; break; end
    end
    check("R9", "pulse during write", hi, NOM/2);
    measure(p, h, b);
    check("R9", "next period uses write", h, 32);
  endtask

  task automatic t_power_down();
    int p, h, b;
    wr(2'd1, 8'h11);
    wr(2'd3, 8'h01);
    @(negedge clk); pd_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "phase_a low in mid-run power-down", int'(phase_a), 0);
    pd_n = 1'b1;
    settle_measure(p, h, b);
    check("R1", "duty restored", h, NOM/2);
    check("R1", "shift and direction restored", b, NOM/4);
  endtask

  initial begin
    t_reset_state();
    t_defaults();
    t_raw_duty();
    t_clamp();
    t_raw_shift();
    t_lead();
    t_offset();
    t_boundary_apply();
    t_power_down();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule